// File: doc/BRIEF.md
# Priority Address Window Decoder

This block turns a 36-bit physical transaction address into a 5-bit target interface ID. Software programs a small bank of ordinary address windows plus one configuration-space window through a simple write port. Every window has an enable, a base address, a power-of-two size code and a target ID. On each valid request the block reports, one cycle later, which target owns the address, whether any window matched and whether the configuration window claimed it.

Windows may overlap. Among ordinary windows the lowest index wins. The configuration window beats all of them. A setup where the configuration window overlaps an enabled window that targets the DRAM controller is illegal. The block flags it continuously so that the setup can be caught before traffic relies on it.

Top module: `addr_win_dec`

## Requirements
- R1: A request with `req_valid` high on a clock edge produces `rsp_valid` high for exactly the following cycle. With no request, `rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_cfg` and `rsp_tgt` are all zero.
- R2: An address inside exactly one enabled ordinary window returns that window's 5-bit target on `rsp_tgt` with `rsp_hit`=1. Example codes: 5'b00100 is the local bus controller and 5'b01111 is the first DRAM controller.
- R3: When several enabled ordinary windows contain the address, the window with the lowest index supplies the target. Example: a 1 MiB window at 0x0_7FF0_0000 in slot 1 wins over a 2 GiB window at 0 in slot 2.
- R4: An address inside the enabled configuration window returns `rsp_cfg`=1, `rsp_hit`=1 and `rsp_tgt`=`CFG_TGT` (default 5'b11110), whatever ordinary windows also contain it.
- R5: A window whose enable bit is 0 never matches.
- R6: An address matched by no window returns `rsp_miss`=1, `rsp_hit`=0 and `rsp_tgt`=0.
- R7: A size code c covers 2^c bytes. Base bits below bit c are ignored, so the region is aligned. Codes below 12 act as 12 (4 KiB), and codes above 36 act as 36 (64 GiB).
- R8: `cfg_conflict` is 1 exactly when the configuration window is enabled and overlaps an enabled ordinary window whose target equals `DRAM_TGT` (default 5'b01111). The flag reflects the window state one cycle after the write that changes it.
- R9: After reset every window is disabled and all outputs are 0.
- R10: A write with `wr_idx` 0..7 loads the ordinary window of that index. A write with `wr_idx` 8 loads the configuration window. Any other index changes nothing. A written window is in effect for a request in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Window write strobe |
| wr_idx | input | 4 | Window slot: 0..7 ordinary, 8 configuration |
| wr_base | input | 36 | Window base address |
| wr_size | input | 6 | Window size code (log2 of bytes) |
| wr_tgt | input | 5 | Window target ID |
| wr_enable | input | 1 | Window enable bit |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 36 | Lookup address |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Some window matched |
| rsp_cfg | output | 1 | Configuration window matched |
| rsp_miss | output | 1 | No window matched |
| rsp_tgt | output | 5 | Resolved target ID |
| cfg_conflict | output | 1 | Illegal configuration/DRAM overlap |

## Verification
Corrupt window state, such as a wrong mask, a lost enable or a wrong slot decode, shows up on `rsp_tgt` and `rsp_hit`/`rsp_miss` in the cycle right after the first request that falls in the affected region. The bench therefore probes both edges of each region and addresses just outside them. A priority inversion shows only where windows nest, so nested and fully covering windows are set up on purpose. Conflict-flag errors show up one cycle after the offending write, and that is where the flag is sampled.

// File: rtl/awd_pkg.sv
package awd_pkg;
    localparam int ADDR_W = 36;
    localparam int TGT_W  = 5;
    localparam int SZC_W  = 6;
    localparam int MIN_SZ = 12;
    localparam int MAX_SZ = 36;

    typedef struct packed {
        logic              en;
        logic [SZC_W-1:0]  szc;
        logic [TGT_W-1:0]  tgt;
        logic [ADDR_W-1:0] base;
    } win_t;

    // Clamp a size code into the supported range.
    function automatic logic [SZC_W-1:0] eff_size(input logic [SZC_W-1:0] c);
        if (int'(c) < MIN_SZ)      return SZC_W'(MIN_SZ);
        else if (int'(c) > MAX_SZ) return SZC_W'(MAX_SZ);
        else                       return c;
    endfunction

    // Bits that must agree between address and base for a match.
    function automatic logic [ADDR_W-1:0] keep_mask(input logic [SZC_W-1:0] c);
        logic [ADDR_W-1:0] m;
        int e;
        e = int'(eff_size(c));
        for (int i = 0; i < ADDR_W; i++) begin
            m[i] = (i >= e);
        end
        return m;
    endfunction

    function automatic logic inside_win(input logic [ADDR_W-1:0] a, input win_t w);
        return w.en && (((a ^ w.base) & keep_mask(w.szc)) == '0);
    endfunction

    // Two aligned power-of-two regions overlap iff they agree above the larger size.
    function automatic logic wins_overlap(input win_t a, input win_t b);
        logic [SZC_W-1:0] ca;
        logic [SZC_W-1:0] cb;
        logic [SZC_W-1:0] big;
        ca  = eff_size(a.szc);
        cb  = eff_size(b.szc);
        big = (ca > cb) ? ca : cb;
        return a.en && b.en && (((a.base ^ b.base) & keep_mask(big)) == '0);
    endfunction
endpackage

// File: rtl/awd_win_regs.sv
module awd_win_regs
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int IDX_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  win_t                    wr_win,
    output win_t [NUM_WIN-1:0]      wins_o,
    output win_t                    cfg_o
);
    typedef struct packed {
        win_t [NUM_WIN-1:0] win;
        win_t               cfg;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                regs_d.win[i] = wr_win;
            end
        end
        if (wr_en && (wr_idx == IDX_W'(NUM_WIN))) begin
            regs_d.cfg = wr_win;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign wins_o = regs_q.win;
    assign cfg_o  = regs_q.cfg;
endmodule

// File: rtl/awd_win_match.sv
module awd_win_match
    import awd_pkg::*;
#(
    parameter int               NUM_WIN  = 8,
    parameter logic [TGT_W-1:0] DRAM_TGT = 5'b01111
) (
    input  logic [ADDR_W-1:0]  addr,
    input  win_t [NUM_WIN-1:0] wins,
    input  win_t               cfg,
    output logic [NUM_WIN-1:0] win_hit,
    output logic               cfg_hit,
    output logic               dram_clash
);
    logic [NUM_WIN-1:0] clash_vec;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        assign win_hit[g]   = inside_win(addr, wins[g]);
        assign clash_vec[g] = (wins[g].tgt == DRAM_TGT) && wins_overlap(wins[g], cfg);
    end

    assign cfg_hit    = inside_win(addr, cfg);
    assign dram_clash = |clash_vec;
endmodule

// File: rtl/awd_prio_pick.sv
module awd_prio_pick #(
    parameter int N  = 8,
    parameter int DW = 5
) (
    input  logic [N-1:0]         req,
    input  logic [N-1:0][DW-1:0] data,
    output logic                 any_o,
    output logic [DW-1:0]        sel_o
);
    // Scan from the top down so the lowest set index is assigned last.
    always_comb begin
        sel_o = '0;
        any_o = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) sel_o = data[i];
        end
    end
endmodule

// File: rtl/addr_win_dec.sv
module addr_win_dec
    import awd_pkg::*;
#(
    parameter int               NUM_WIN  = 8,
    parameter logic [TGT_W-1:0] DRAM_TGT = 5'b01111,
    parameter logic [TGT_W-1:0] CFG_TGT  = 5'b11110,
    localparam int              IDX_W    = $clog2(NUM_WIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [SZC_W-1:0]  wr_size,
    input  logic [TGT_W-1:0]  wr_tgt,
    input  logic              wr_enable,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_cfg,
    output logic              rsp_miss,
    output logic [TGT_W-1:0]  rsp_tgt,
    output logic              cfg_conflict
);
    typedef struct packed {
        logic             valid;
        logic             hit;
        logic             cfg;
        logic             miss;
        logic [TGT_W-1:0] tgt;
        logic             conflict;
    } out_t;

    win_t                          wr_win;
    win_t [NUM_WIN-1:0]            wins;
    win_t                          cfg_win;
    logic [NUM_WIN-1:0]            win_hit;
    logic [NUM_WIN-1:0][TGT_W-1:0] win_tgts;
    logic                          cfg_hit;
    logic                          dram_clash;
    logic                          any_hit;
    logic [TGT_W-1:0]              pick_tgt;
    out_t                          out_d, out_q;

    assign wr_win = '{en: wr_enable, szc: wr_size, tgt: wr_tgt, base: wr_base};

    awd_win_regs #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_win (wr_win),
        .wins_o (wins),
        .cfg_o  (cfg_win)
    );

    awd_win_match #(.NUM_WIN(NUM_WIN), .DRAM_TGT(DRAM_TGT)) u_match (
        .addr       (req_addr),
        .wins       (wins),
        .cfg        (cfg_win),
        .win_hit    (win_hit),
        .cfg_hit    (cfg_hit),
        .dram_clash (dram_clash)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_tgt
        assign win_tgts[g] = wins[g].tgt;
    end

    awd_prio_pick #(.N(NUM_WIN), .DW(TGT_W)) u_pick (
        .req   (win_hit),
        .data  (win_tgts),
        .any_o (any_hit),
        .sel_o (pick_tgt)
    );

    always_comb begin
        out_d          = '0;
        out_d.conflict = dram_clash;
        if (req_valid) begin
            out_d.valid = 1'b1;
            if (cfg_hit) begin
                out_d.hit = 1'b1;
                out_d.cfg = 1'b1;
                out_d.tgt = CFG_TGT;
            end else if (any_hit) begin
                out_d.hit = 1'b1;
                out_d.tgt = pick_tgt;
            end else begin
                out_d.miss = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rsp_valid    = out_q.valid;
    assign rsp_hit      = out_q.hit;
    assign rsp_cfg      = out_q.cfg;
    assign rsp_miss     = out_q.miss;
    assign rsp_tgt      = out_q.tgt;
    assign cfg_conflict = out_q.conflict;
endmodule

// File: rtl/addr_win_dec_chk.sv
module addr_win_dec_chk
    import awd_pkg::*;
#(
    parameter logic [TGT_W-1:0] CFG_TGT = 5'b11110
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_cfg,
    input logic             rsp_miss,
    input logic [TGT_W-1:0] rsp_tgt
);
    AST_REQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_miss && !rsp_cfg && rsp_tgt == '0)); // R1
    AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss)); // R6
    AST_MISS_TGT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_tgt == '0 && !rsp_cfg)); // R6
    AST_CFG_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cfg |-> (rsp_hit && rsp_tgt == CFG_TGT)); // R4
endmodule

bind addr_win_dec addr_win_dec_chk #(.CFG_TGT(CFG_TGT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_cfg   (rsp_cfg),
    .rsp_miss  (rsp_miss),
    .rsp_tgt   (rsp_tgt)
);

// File: tb/tb_addr_win_dec.sv
module tb_addr_win_dec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [35:0] wr_base = '0;
    logic [5:0]  wr_size = '0;
    logic [4:0]  wr_tgt = '0;
    logic        wr_enable = 1'b0;
    logic        req_valid = 1'b0;
    logic [35:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_cfg, rsp_miss, cfg_conflict;
    logic [4:0]  rsp_tgt;

    localparam logic [4:0] CFG_ID = 5'b11110;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    addr_win_dec dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_base(wr_base), .wr_size(wr_size), .wr_tgt(wr_tgt),
        .wr_enable(wr_enable), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_cfg(rsp_cfg),
        .rsp_miss(rsp_miss), .rsp_tgt(rsp_tgt), .cfg_conflict(cfg_conflict)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // All tasks start and end on a falling edge.
    task automatic wr_win(input logic [3:0] idx, input logic [35:0] base,
                          input logic [5:0] sz, input logic [4:0] tgt, input logic en);
        wr_en = 1'b1; wr_idx = idx; wr_base = base; wr_size = sz; wr_tgt = tgt; wr_enable = en;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Expected: hit with target, or miss when exp_hit is 0.
    task automatic look(input string tag, input logic [35:0] addr, input logic exp_hit,
                        input logic exp_cfg, input logic [4:0] exp_tgt);
        req_valid = 1'b1; req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, rsp_valid, 1);
        check({tag, " hit"},   rsp_hit, exp_hit);
        check({tag, " miss"},  rsp_miss, !exp_hit);
        check({tag, " cfg"},   rsp_cfg, exp_cfg);
        check({tag, " tgt"},   rsp_tgt, exp_tgt);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R9 reset valid", rsp_valid, 0);
        check("R9 reset tgt", rsp_tgt, 0);
        check("R9 reset conflict", cfg_conflict, 0);
        rst_n = 1'b1;
        @(negedge clk);
        look("R9 R6 empty table miss", 36'h0_0000_0000, 0, 0, 0);
    endtask

    task automatic t_nested();
        wr_win(2, 36'h0_0000_0000, 31, 5'b01111, 1);
        wr_win(1, 36'h0_7FF0_0000, 20, 5'b00100, 1);
        look("R3 nested inner", 36'h0_7FF8_1234, 1, 0, 5'b00100);
        look("R3 nested inner top", 36'h0_7FFF_FFFF, 1, 0, 5'b00100);
        look("R2 outer only", 36'h0_7FEF_FFFF, 1, 0, 5'b01111);
        look("R6 above outer", 36'h0_8000_0000, 0, 0, 0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        check("R1 idle valid", rsp_valid, 0);
        check("R1 idle hit", rsp_hit, 0);
        check("R1 idle tgt", rsp_tgt, 0);
    endtask

    task automatic t_align_clamp();
        wr_win(3, 36'h1_2345_6789, 16, 5'h07, 1);
        look("R7 aligned low", 36'h1_2345_0000, 1, 0, 5'h07);
        look("R7 aligned high", 36'h1_2345_FFFF, 1, 0, 5'h07);
        look("R7 aligned past", 36'h1_2346_0000, 0, 0, 0);
        wr_win(4, 36'h2_0000_0000, 3, 5'h09, 1);
        look("R7 min clamp in", 36'h2_0000_0FFF, 1, 0, 5'h09);
        look("R7 min clamp out", 36'h2_0000_1000, 0, 0, 0);
    endtask

    task automatic t_disable();
        wr_win(0, 36'h0_7FF0_0000, 20, 5'h02, 0);
        look("R5 disabled slot0", 36'h0_7FF0_0010, 1, 0, 5'b00100);
        wr_win(0, 36'h0_7FF0_0000, 20, 5'h02, 1);
        look("R3 slot0 beats slot1", 36'h0_7FF0_0010, 1, 0, 5'h02);
    endtask

    task automatic t_bad_index();
        wr_win(9, 36'h0_0000_0000, 36, 5'h15, 1);
        look("R10 bad index ignored", 36'h9_0000_0000, 0, 0, 0);
    endtask

    task automatic t_cfg();
        wr_win(8, 36'h3_0000_0000, 20, 5'h00, 1);
        @(negedge clk);
        check("R8 no dram overlap", cfg_conflict, 0);
        look("R4 cfg hit", 36'h3_0000_0010, 1, 1, CFG_ID);
    endtask

    task automatic t_conflict();
        wr_win(8, 36'h0_4000_0000, 20, 5'h00, 1);
        @(negedge clk);
        check("R8 dram overlap flagged", cfg_conflict, 1);
        look("R4 cfg beats dram window", 36'h0_4000_0004, 1, 1, CFG_ID);
        look("R10 old cfg region gone", 36'h3_0000_0010, 0, 0, 0);
        wr_win(2, 36'h0_0000_0000, 31, 5'b01111, 0);
        @(negedge clk);
        check("R8 flag clears", cfg_conflict, 0);
    endtask

    task automatic t_full();
        wr_win(7, 36'h0_0000_0000, 63, 5'h11, 1);
        look("R7 max clamp covers top", 36'hF_0000_0000, 1, 0, 5'h11);
        look("R4 cfg beats slot7", 36'h0_4000_0004, 1, 1, CFG_ID);
        look("R3 slot0 beats slot7", 36'h0_7FF0_0010, 1, 0, 5'h02);
        @(negedge clk);
        check("R8 non-dram overlap ok", cfg_conflict, 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_nested();
        t_idle();
        t_align_clamp();
        t_disable();
        t_bad_index();
        t_cfg();
        t_conflict();
        t_full();
        t_idle();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=0x0 expected=0x1");
            summary();
            $finish;
        end
    end
endmodule